// File: doc/BRIEF.md
# Perfect-Filter Setup Frame Generator

This block streams out the fixed 192-byte frame that loads a perfect address filter. The first filter entry carries the station's own 48-bit address. Every other entry carries the all-ones broadcast address.

Each 6-byte address takes up 12 bytes of the frame. It is split into three 16-bit halves, and each half is followed by two filler bytes. Filler bytes and all unused entries read 0xFF.

A one-cycle start pulse latches the station address and begins the stream. Bytes leave through a valid/ready handshake. The last byte is marked by `out_last`. Alongside the stream, the block drives two constant descriptor fields: a control word that flags the frame as a setup frame, and the buffer length.

Top module: `setup_frame_gen`

## Requirements
- R1: A frame is exactly 192 byte transfers long. `out_last` is high on the 192nd byte (offset 191) and on no other byte.
- R2: Station byte 0 is `station_addr[47:40]` and station byte 5 is `station_addr[7:0]`. Bytes 0 and 1 appear at frame offsets 0 and 1. Bytes 2 and 3 appear at offsets 4 and 5. Bytes 4 and 5 appear at offsets 8 and 9.
- R3: Every frame offset not named in R2 carries 0xFF. This includes offsets 2, 3, 6, 7, 10, 11 and 12 through 191.
- R4: A byte is transferred only in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_data` and `out_last` hold their values.
- R5: A start that arrives while `busy` is high is ignored, including a start in the cycle of the final transfer. The address is captured when start is accepted, so later changes to `station_addr` do not alter the frame being sent.
- R6: `busy` rises in the cycle after an accepted start and falls in the cycle after the final transfer. `out_valid` equals `busy`, and offset 0 is presented in the first busy cycle.
- R7: `desc_ctrl` is constantly 0x024, which is the setup-frame flag (bit 5) plus the chain flag (bit 2). `desc_len` is constantly 192.
- R8: While reset is asserted and right after it, `busy`, `out_valid` and `out_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one frame (accepted when idle) |
| station_addr | input | 48 | Station address, byte 0 in the top bits |
| out_data | output | 8 | Current frame byte |
| out_valid | output | 1 | Byte on `out_data` is valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_last | output | 1 | Current byte is offset 191 |
| busy | output | 1 | A frame is in progress |
| desc_ctrl | output | 10 | Descriptor control bits for the setup frame |
| desc_len | output | 11 | Descriptor buffer length |

## Verification
A start accepted at a clock edge shows `busy`, `out_valid` and offset 0 before the next edge. Each byte taken with `out_ready` high is replaced by the next offset before the following edge. `busy` falls in the cycle after offset 191 is taken.

The bench drives its inputs and samples its outputs on the falling edge. Every byte is compared with an offset computed in the bench, so each check sees the state one rising edge after the stimulus it depends on. The sweeps send full frames with continuous, alternating and one-in-three stalled `out_ready` patterns. They also inject starts and address changes in the middle of a frame and at its final transfer.

// File: rtl/setup_frame_gen.sv
module setup_frame_gen #(
  parameter int          FRAME_BYTES = 192,
  parameter logic [9:0]  CTRL_SETUP  = 10'h024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [47:0] station_addr,
  output logic [7:0]  out_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_last,
  output logic        busy,
  output logic [9:0]  desc_ctrl,
  output logic [10:0] desc_len
);
  localparam int IDX_W = $clog2(FRAME_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  logic [IDX_W-1:0] idx;
  logic [47:0]      addr_q;
  logic             take;

  assign out_valid = busy;
  assign out_last  = busy && (idx == LAST_IDX);
  assign take      = out_valid && out_ready;
  assign desc_ctrl = CTRL_SETUP;
  assign desc_len  = 11'(FRAME_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      addr_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        idx    <= '0;
        addr_q <= station_addr;
      end
    end else if (take) begin
      if (idx == LAST_IDX) busy <= 1'b0;
      else                 idx  <= idx + 1'b1;
    end
  end

  always_comb begin
    out_data = 8'hFF;
    case (idx)
      IDX_W'(0): out_data = addr_q[47:40];
      IDX_W'(1): out_data = addr_q[39:32];
      IDX_W'(4): out_data = addr_q[31:24];
      IDX_W'(5): out_data = addr_q[23:16];
      IDX_W'(8): out_data = addr_q[15:8];
      IDX_W'(9): out_data = addr_q[7:0];
      default:   out_data = 8'hFF;
    endcase
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R1
  AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> out_data == $past(station_addr[47:40])); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R4
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R6
  AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !busy); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(out_ready && out_last) |=> busy); // R5
endmodule

// File: tb/setup_frame_gen_bench.sv
module setup_frame_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [47:0] station_addr = '0;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_valid, out_last, busy;
  logic [9:0]  desc_ctrl;
  logic [10:0] desc_len;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  setup_frame_gen u_setup_frame_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .station_addr(station_addr),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .busy(busy), .desc_ctrl(desc_ctrl), .desc_len(desc_len)
  );

  function automatic logic [7:0] exp_byte(input logic [47:0] a, input int i);
    case (i)
      0: return a[47:40];
      1: return a[39:32];
      4: return a[31:24];
      5: return a[23:16];
      8: return a[15:8];
      9: return a[7:0];
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode: 0 ready always, 1 alternating, 2 stall one in three
  task automatic run_frame(input logic [47:0] a, input int mode, input bit inject);
    int idx = 0;
    int cyc = 0;
    @(negedge clk);
    station_addr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6 busy after start", busy, 1);
    chk("R6 valid equals busy", out_valid, busy);
    while (idx < 192 && cyc < 2000) begin
      chk("R6 valid during frame", out_valid, 1);
      chk(((idx < 12) && (idx % 4 < 2)) ? "R2 address byte" : "R3 filler byte",
          out_data, exp_byte(a, idx));
      chk("R1 last flag", out_last, idx == 191);
      case (mode)
        0: out_ready = 1'b1;
        1: out_ready = cyc[0];
        default: out_ready = (cyc % 3) != 0;
      endcase
      start = 1'b0;
      if (inject && idx == 50) begin
        start = 1'b1;
        station_addr = ~a;
      end
      if (inject && idx == 191 && out_ready) start = 1'b1;
      if (out_ready) idx++;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    chk("R1 frame completes", idx, 192);
    chk("R6 busy drops after last", busy, 0);
    chk("R5 no restart after stray start", out_valid, 0);
    chk("R1 last low when idle", out_last, 0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 busy in reset", busy, 0);
    chk("R8 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 busy after reset", busy, 0);
    chk("R8 last after reset", out_last, 0);
    chk("R7 control word", desc_ctrl, 10'h024);
    chk("R7 length", desc_len, 192);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R4 no transfer while idle", out_valid, 0);
    out_ready = 1'b0;
    run_frame(48'h0123_4567_89AB, 0, 1'b0);
    run_frame(48'hA5C3_0F96_E17B, 1, 1'b1);
    run_frame(48'hFEDC_BA98_7654, 2, 1'b1);
    run_frame(48'h0000_0000_0000, 0, 1'b1);
    run_frame(48'h8001_4002_2004, 2, 1'b0);
    chk("R7 control word after frames", desc_ctrl, 10'h024);
    chk("R7 length after frames", desc_len, 192);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule